// File: doc/BRIEF.md
# Privileged Special Register Access Unit

This block holds the numbered special registers of a 32-bit core and carries out the four instructions that move data between a general register and those registers. The four operations are read, write, swap, and an atomic operation that reads the status word and replaces its interrupt-level field. Each operation is presented for one cycle with a register number, a general-register operand and a 4-bit immediate. The read result appears combinationally in the same cycle, and any register update takes effect at the next clock edge.

The unit checks privilege on every operation. In a nonzero ring, any access to a register numbered at or above a privilege boundary (64 by default) raises a fault flag instead of being performed. The atomic level operation raises the same fault in a nonzero ring. The exception controller uses this flag. The unit also publishes the status word and the effective interrupt level derived from it. When the exception-mode bit is set, that level is lifted to a configured floor.

Top module: `srf_access_unit`

## Requirements
- R1: After reset the status word is 0x0000001F, every other implemented register reads 0, and the effective level is 15.
- R2: The implemented registers are numbers 3, 12, 177, 192, 209, 230 (the status word), 232 and 238. A read (op code 0) returns the current value of the addressed register on `rd_data` in the same cycle.
- R3: A read of any number outside that list returns 0, and a write to such a number changes no register.
- R4: A write (op code 1) stores `gr_in` in the addressed register, and the new value is visible from the next cycle. A write drives `rd_data` to 0.
- R5: A swap (op code 2) returns the old register value and stores `gr_in` into the register in the same operation.
- R6: The level operation (op code 3) returns the whole old status word. It then sets status bits 3:0 to `imm` and leaves bits 31:4 unchanged.
- R7: In a nonzero ring, these cases assert `priv_fault` in the same cycle: read, write or swap of a number at or above 64, and any level operation. A faulting operation returns 0 and changes no register. Numbers below 64 stay accessible.
- R8: With the MMU option enabled, the ring is status bits 7:6. With the option disabled, the ring is always 0.
- R9: `cur_level` equals status bits 3:0. The exception exception: when status bit 4 is set and the configured floor exceeds bits 3:0, `cur_level` equals the floor.
- R10: A read result always reflects the register contents before any write issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op | input | 2 | 0 read, 1 write, 2 swap, 3 level operation |
| sr_num | input | 8 | Special register number |
| gr_in | input | 32 | General-register operand |
| imm | input | 4 | New interrupt level for the level operation |
| rd_data | output | 32 | Value returned to the general register |
| priv_fault | output | 1 | Privilege violation for the current operation |
| status_word | output | 32 | Current status register |
| cur_level | output | 4 | Effective interrupt level |

## Verification
The assertions check these properties on every cycle:
- A faulting operation leaves the status word unchanged.
- The level operation alters only bits 3:0 and loads them with the immediate.
- A write to the status word lands at the next edge.
- The effective level never falls below the raw field and never falls below the floor while exception mode is set.

The following behaviours need the bench's reference model and scenarios:
- The contents of the other registers.
- The zero result and ignored writes for unimplemented numbers.
- Swap returning the pre-write value.
- The reset values.
- Lock-out in a nonzero ring after a status write changes the ring.

// File: rtl/srf_pkg.sv
package srf_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SWAP  = 2'd2,
    OP_LEVEL = 2'd3
  } srf_op_e;

  localparam int NUM_IMPL = 8;

  localparam logic [7:0] SRN_SHIFT  = 8'd3;
  localparam logic [7:0] SRN_CMPVAL = 8'd12;
  localparam logic [7:0] SRN_RETPC  = 8'd177;
  localparam logic [7:0] SRN_DBLPC  = 8'd192;
  localparam logic [7:0] SRN_SCRTCH = 8'd209;
  localparam logic [7:0] SRN_STATUS = 8'd230;
  localparam logic [7:0] SRN_CAUSE  = 8'd232;
  localparam logic [7:0] SRN_FADDR  = 8'd238;

  // status word field positions
  localparam int LVL_LSB  = 0;
  localparam int LVL_W    = 4;
  localparam int EXCM_BIT = 4;
  localparam int RING_LSB = 6;
  localparam int RING_W   = 2;

  function automatic logic [7:0] impl_num(input int idx);
    case (idx)
      0:       return SRN_SHIFT;
      1:       return SRN_CMPVAL;
      2:       return SRN_RETPC;
      3:       return SRN_DBLPC;
      4:       return SRN_SCRTCH;
      5:       return SRN_STATUS;
      6:       return SRN_CAUSE;
      default: return SRN_FADDR;
    endcase
  endfunction

  function automatic int status_idx();
    int r = 0;
    for (int i = 0; i < NUM_IMPL; i++)
      if (impl_num(i) == SRN_STATUS) r = i;
    return r;
  endfunction

  function automatic logic [LVL_W-1:0] eff_level(input logic [31:0] ps,
                                                 input logic [LVL_W-1:0] floor_lvl);
    logic [LVL_W-1:0] raw;
    raw = ps[LVL_LSB +: LVL_W];
    if (ps[EXCM_BIT] && (floor_lvl > raw)) return floor_lvl;
    return raw;
  endfunction

  function automatic logic [RING_W-1:0] ring_of(input logic [31:0] ps, input bit mmu);
    return mmu ? ps[RING_LSB +: RING_W] : '0;
  endfunction

endpackage

// File: rtl/srf_guard.sv
module srf_guard
  import srf_pkg::*;
#(
  parameter bit HAS_MMU   = 1'b1,
  parameter int PRIV_BASE = 64
) (
  input  logic              op_valid,
  input  logic [1:0]        op,
  input  logic [7:0]        sr_num,
  input  logic [31:0]       ps,
  output logic [RING_W-1:0] ring,
  output logic              fault
);
  localparam logic [7:0] BOUND = 8'(PRIV_BASE);

  logic high_num;
  logic needs_priv;

  assign ring       = ring_of(ps, HAS_MMU);
  assign high_num   = (sr_num >= BOUND);
  assign needs_priv = (op == OP_LEVEL) || high_num;
  assign fault      = op_valid && (ring != '0) && needs_priv;
endmodule

// File: rtl/srf_bank.sv
module srf_bank
  import srf_pkg::*;
#(
  parameter int          W        = 32,
  parameter logic [31:0] PS_RESET = 32'h0000_001F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rd_num,
  output logic [W-1:0]     rd_data,
  input  logic             wr_en,
  input  logic [7:0]       wr_num,
  input  logic [W-1:0]     wr_data,
  input  logic             lvl_en,
  input  logic [LVL_W-1:0] lvl_val,
  output logic [W-1:0]     ps_q
);
  localparam int PS_IDX = status_idx();

  logic [W-1:0]        val    [NUM_IMPL];
  logic [NUM_IMPL-1:0] rd_sel;

  for (genvar i = 0; i < NUM_IMPL; i++) begin : g_reg
    localparam logic [7:0] N = impl_num(i);
    logic [W-1:0] q;
    if (N == SRN_STATUS) begin : g_status
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= PS_RESET[W-1:0];
        else if (wr_en && wr_num == N)
          q <= wr_data;
        else if (lvl_en)
          q[LVL_LSB +: LVL_W] <= lvl_val;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= '0;
        else if (wr_en && wr_num == N)
          q <= wr_data;
      end
    end
    assign val[i]    = q;
    assign rd_sel[i] = (rd_num == N);
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_IMPL; i++)
      if (rd_sel[i]) rd_data = rd_data | val[i];
  end

  assign ps_q = val[PS_IDX];
endmodule

// File: rtl/srf_level.sv
module srf_level
  import srf_pkg::*;
#(
  parameter logic [LVL_W-1:0] EXCM_FLOOR = 4'd3
) (
  input  logic [31:0]      ps,
  output logic [LVL_W-1:0] level
);
  assign level = eff_level(ps, EXCM_FLOOR);
endmodule

// File: rtl/srf_access_unit.sv
module srf_access_unit
  import srf_pkg::*;
#(
  parameter bit          HAS_MMU    = 1'b1,
  parameter logic [3:0]  EXCM_FLOOR = 4'd3,
  parameter int          PRIV_BASE  = 64,
  parameter logic [31:0] PS_RESET   = 32'h0000_001F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [1:0]  op,
  input  logic [7:0]  sr_num,
  input  logic [31:0] gr_in,
  input  logic [3:0]  imm,
  output logic [31:0] rd_data,
  output logic        priv_fault,
  output logic [31:0] status_word,
  output logic [3:0]  cur_level
);
  logic [RING_W-1:0] ring;
  logic              fault;
  logic              go;
  logic              do_write;
  logic              do_level;
  logic [7:0]        bank_rd_num;
  logic [31:0]       bank_rd;
  logic [31:0]       ps_q;

  srf_guard #(.HAS_MMU(HAS_MMU), .PRIV_BASE(PRIV_BASE)) u_guard (
    .op_valid(op_valid), .op(op), .sr_num(sr_num), .ps(ps_q),
    .ring(ring), .fault(fault)
  );

  assign go          = op_valid && !fault;
  assign do_write    = go && (op == OP_WRITE || op == OP_SWAP);
  assign do_level    = go && (op == OP_LEVEL);
  assign bank_rd_num = (op == OP_LEVEL) ? SRN_STATUS : sr_num;

  srf_bank #(.W(32), .PS_RESET(PS_RESET)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .rd_num(bank_rd_num), .rd_data(bank_rd),
    .wr_en(do_write), .wr_num(sr_num), .wr_data(gr_in),
    .lvl_en(do_level), .lvl_val(imm),
    .ps_q(ps_q)
  );

  srf_level #(.EXCM_FLOOR(EXCM_FLOOR)) u_level (.ps(ps_q), .level(cur_level));

  assign rd_data     = (go && op != OP_WRITE) ? bank_rd : 32'd0;
  assign priv_fault  = fault;
  assign status_word = ps_q;

  // R7: a refused operation leaves the status word untouched
  a_r7_fault_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |=> $stable(status_word));

  // R6: level operation replaces bits 3:0 with the immediate
  a_r6_level_field: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_LEVEL && !priv_fault) |=> status_word[3:0] == $past(imm));

  // R6: level operation preserves the upper bits
  a_r6_level_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_LEVEL && !priv_fault) |=> status_word[31:4] == $past(status_word[31:4]));

  // R4: a write to the status word lands at the next edge
  a_r4_status_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_WRITE && sr_num == SRN_STATUS && !priv_fault)
      |=> status_word == $past(gr_in));

  // R9: the effective level is never below the raw field
  a_r9_level_min: assert property (@(posedge clk) disable iff (!rst_n)
    cur_level >= status_word[3:0]);

  // R9: while in exception mode the level is at least the floor
  a_r9_level_floor: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[EXCM_BIT] |-> cur_level >= EXCM_FLOOR);

  // R8: with the MMU option off, no operation ever faults
  a_r8_no_ring: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_MMU |-> !priv_fault);
endmodule

// File: tb/srf_access_unit_test.sv
module srf_access_unit_test;
  localparam logic [3:0] FLOOR = 4'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [7:0]  sr_num = 8'd0;
  logic [31:0] gr_in = 32'd0;
  logic [3:0]  imm = 4'd0;
  logic [31:0] rd_data;
  logic        priv_fault;
  logic [31:0] status_word;
  logic [3:0]  cur_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m [256];

  always #5 clk = ~clk;

  srf_access_unit #(.HAS_MMU(1'b1), .EXCM_FLOOR(FLOOR)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .sr_num(sr_num),
    .gr_in(gr_in), .imm(imm), .rd_data(rd_data), .priv_fault(priv_fault),
    .status_word(status_word), .cur_level(cur_level)
  );

  function automatic bit is_impl(input logic [7:0] n);
    return n == 3 || n == 12 || n == 177 || n == 192 || n == 209 ||
           n == 230 || n == 232 || n == 238;
  endfunction

  function automatic logic [3:0] exp_level(input logic [31:0] ps);
    if (ps[4] && ps[3:0] < FLOOR) return FLOOR;
    return ps[3:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) m[i] = 32'd0;
    m[230] = 32'h1F;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    op_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic do_op(input logic [1:0] o, input logic [7:0] n,
                       input logic [31:0] g, input logic [3:0] im, input string req);
    logic        ef;
    logic [31:0] er;
    logic [7:0]  rn;
    @(negedge clk);
    op_valid = 1'b1; op = o; sr_num = n; gr_in = g; imm = im;
    #4;
    ef = (m[230][7:6] != 2'd0) && (o == 2'd3 || n >= 8'd64);
    rn = (o == 2'd3) ? 8'd230 : n;
    er = (ef || o == 2'd1) ? 32'd0 : (is_impl(rn) ? m[rn] : 32'd0);
    chk(priv_fault == ef, "R7 fault", {31'd0, priv_fault}, {31'd0, ef});
    chk(rd_data == er, req, rd_data, er);
    if (!ef) begin
      if ((o == 2'd1 || o == 2'd2) && is_impl(n)) m[n] = g;
      if (o == 2'd3) m[230][3:0] = im;
    end
    @(posedge clk);
    #1;
    op_valid = 1'b0;
    chk(status_word == m[230], "R4/R6 status", status_word, m[230]);
    chk(cur_level == exp_level(m[230]), "R9 level", {28'd0, cur_level},
        {28'd0, exp_level(m[230])});
  endtask

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    do_reset();
    #1;
    // R1 reset state
    chk(status_word == 32'h1F, "R1 status", status_word, 32'h1F);
    chk(cur_level == 4'd15, "R1 level", {28'd0, cur_level}, 32'd15);
    do_op(2'd0, 8'd177, 32'd0, 4'd0, "R1 reg zero");
    // R2 / R4
    do_op(2'd1, 8'd3, 32'h0000_0011, 4'd0, "R4 write rd zero");
    do_op(2'd0, 8'd3, 32'd0, 4'd0, "R2 read");
    // R5 / R10 swap
    do_op(2'd1, 8'd192, 32'hAAAA_5555, 4'd0, "R4 write");
    do_op(2'd2, 8'd192, 32'h1234_5678, 4'd0, "R5 R10 swap old");
    do_op(2'd0, 8'd192, 32'd0, 4'd0, "R5 swap new");
    // R3 unimplemented
    do_op(2'd1, 8'd100, 32'hDEAD_BEEF, 4'd0, "R3 write");
    do_op(2'd0, 8'd100, 32'd0, 4'd0, "R3 read zero");
    do_op(2'd2, 8'd5, 32'h77, 4'd0, "R3 swap");
    do_op(2'd0, 8'd5, 32'd0, 4'd0, "R3 read zero");
    // R6 level operation, R9 floor
    do_op(2'd3, 8'd0, 32'd0, 4'd2, "R6 old status");
    do_op(2'd1, 8'd230, 32'h0000_0001, 4'd0, "R9 plain");
    do_op(2'd1, 8'd230, 32'h0000_0015, 4'd0, "R9 above floor");
    do_op(2'd1, 8'd230, 32'h0000_0011, 4'd0, "R9 below floor");
    // R7 / R8 nonzero ring
    do_op(2'd1, 8'd230, 32'h0000_0040, 4'd0, "R8 set ring");
    do_op(2'd0, 8'd177, 32'd0, 4'd0, "R7 read high");
    do_op(2'd1, 8'd230, 32'h0, 4'd0, "R7 write high");
    do_op(2'd3, 8'd0, 32'd0, 4'd9, "R7 level op");
    do_op(2'd1, 8'd12, 32'h0BAD_F00D, 4'd0, "R7 low write");
    do_op(2'd0, 8'd12, 32'd0, 4'd0, "R7 low read");
    do_op(2'd1, 8'd63, 32'h1, 4'd0, "R7 boundary low");
    do_op(2'd0, 8'd64, 32'd0, 4'd0, "R7 boundary high");
    do_reset();
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [7:0] n;
      int pick;
      if (k % 60 == 59) do_reset();
      pick = $urandom_range(0, 9);
      case (pick % 8)
        0: n = 8'd3;   1: n = 8'd12;  2: n = 8'd177; 3: n = 8'd192;
        4: n = 8'd209; 5: n = 8'd230; 6: n = 8'd232; default: n = 8'd238;
      endcase
      if (pick >= 8) n = 8'($urandom_range(0, 255));
      do_op(2'($urandom_range(0, 3)), n, $urandom(), 4'($urandom_range(0, 15)),
            "R2 R5 R6 R10 random");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule